// File: doc/BRIEF.md
# Banked Scratch Memory with Same-Address Broadcast

This block is a scratch memory shared by a group of lanes that issue one request together. Each lane brings its own word address, its own write enable and its own write word. The storage is split into banks, and the low bits of a word address pick the bank. In each service cycle a bank can reach one row only. Every lane that names that exact address is served in the same cycle: a read returns the word to all of them, and a write to the word needs only that one cycle.

When lanes land in the same bank at different addresses, the bank serves them one address per cycle. The request therefore takes as many service cycles as the largest count of distinct addresses found in any single bank. This can be one cycle when every lane reads the same word, and it can be one cycle per lane when every lane hits a different row of one bank. A controller with three named states runs the request. IDLE waits. SERVE performs one round per cycle. DONE raises the completion pulse for one cycle. The transitions are IDLE→SERVE on an accepted request, SERVE→SERVE while some lane is still pending, SERVE→DONE on the last round, DONE→SERVE on a request accepted in the pulse cycle, and DONE→IDLE otherwise.

Top module: `bsm_top`

## Requirements
- R1: After reset, `done` is low, `ready` is high and every stored word reads as zero.
- R2: `ready` is low during SERVE. A request presented while `ready` is low is ignored, and lane inputs that change after acceptance do not affect the result.
- R3: A word address `a` lives in bank `a mod BANKS` (its low log2(BANKS) bits) at row `a / BANKS` (the remaining upper bits).
- R4: In each SERVE cycle, each bank serves the address of its lowest-numbered pending lane. All pending lanes with that identical address are served in the same cycle.
- R5: When all lanes name one address, the request completes after a single round. All lanes receive the same word.
- R6: Let D be the largest number of distinct addresses that map to any one bank. Then `done` is high in the cycle that follows the D-th rising edge after the accepting edge. The request spans D+1 cycles, counting the accepting cycle, which lies between 2 and LANES+1.
- R7: A reading lane receives the word as it stood before the request, even when other lanes of the same request write that address.
- R8: When several lanes of one request write the same address, the word written by the highest-numbered of them is stored.
- R9: `done` is a single-cycle pulse. All lanes of `rdata` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| ready | output | 1 | High when a request can be accepted |
| lane_we | input | LANES | Per-lane write enable |
| lane_addr | input | LANES*AW | Per-lane word address, lane 0 in the low bits |
| lane_wdata | input | LANES*W | Per-lane write word |
| lane_rdata | output | LANES*W | Per-lane read word, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle. Each service round grants only pending lanes and always grants at least one. The controller stays in SERVE while lanes remain. The busy time never exceeds one round per lane. The completion pulse never lasts two cycles. Other properties can only be shown by the bench's scenarios, which compare against an arithmetic model: the exact latency derived from the worst bank's distinct-address count, broadcast of one word to many lanes, read-before-write within a request, highest-lane-wins write merging, and immunity to inputs presented while busy.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_DONE  = 2'd2
    } bsm_state_e;
endpackage

// File: rtl/bsm_bank_arbiter.sv
module bsm_bank_arbiter #(
    parameter int LANES = 64,
    parameter int AW    = 9,
    parameter int BW    = 5,
    parameter int W     = 32,
    parameter int BANK  = 0
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*W-1:0]  lane_wdata,
    output logic [LANES-1:0]    grant,
    output logic                bank_wr,
    output logic [W-1:0]        bank_wword,
    output logic [AW-BW-1:0]    bank_row
);
    logic          found;
    logic [AW-1:0] lead;

    // Lowest-numbered pending lane of this bank picks the address.
    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && pend[i] &&
                lane_addr[i*AW +: BW] == BW'(BANK)) begin
                found = 1'b1;
                lead  = lane_addr[i*AW +: AW];
            end
        end
    end

    // Every pending lane naming that exact address joins the round;
    // among its writers the last one in lane order sets the word.
    always_comb begin
        grant      = '0;
        bank_wr    = 1'b0;
        bank_wword = '0;
        for (int i = 0; i < LANES; i++) begin
            grant[i] = found && pend[i] && (lane_addr[i*AW +: AW] == lead);
            if (grant[i] && lane_we[i]) begin
                bank_wr    = 1'b1;
                bank_wword = lane_wdata[i*W +: W];
            end
        end
    end

    assign bank_row = lead[AW-1:BW];
endmodule

// File: rtl/bsm_bank.sv
module bsm_bank #(
    parameter int ROWS = 16,
    parameter int W    = 32,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [RW-1:0] row,
    input  logic [W-1:0]  wword,
    output logic [W-1:0]  rword
);
    logic [W-1:0] mem [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (wr) begin
            mem[row] <= wword;
        end
    end

    // Read is combinational; a same-edge write lands after capture.
    assign rword = mem[row];
endmodule

// File: rtl/bsm_top.sv
module bsm_top #(
    parameter int LANES = 64,
    parameter int BANKS = 32,
    parameter int ROWS  = 16,
    parameter int W     = 32,
    localparam int BW   = $clog2(BANKS),
    localparam int RW   = $clog2(ROWS),
    localparam int AW   = BW + RW,
    localparam int CW   = $clog2(LANES + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    output logic                ready,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*W-1:0]  lane_wdata,
    output logic [LANES*W-1:0]  lane_rdata,
    output logic                done
);
    import bsm_pkg::*;

    bsm_state_e          state_q, state_d;
    logic [LANES-1:0]    pend_q;
    logic [LANES-1:0]    we_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES*W-1:0]  wdata_q;
    logic [LANES*W-1:0]  rdata_q;
    logic [CW-1:0]       busy_cnt;

    logic [LANES-1:0]    gnt_b [BANKS];
    logic [W-1:0]        bank_rd [BANKS];
    logic [LANES-1:0]    gnt;
    logic                serving;
    logic                accept;
    logic                last_round;

    assign serving    = (state_q == ST_SERVE);
    assign accept     = req && ready;
    assign last_round = ((pend_q & ~gnt) == '0);

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic            wr_b;
            logic [W-1:0]    ww_b;
            logic [RW-1:0]   row_b;

            bsm_bank_arbiter #(
                .LANES(LANES), .AW(AW), .BW(BW), .W(W), .BANK(b)
            ) u_arb (
                .pend       (serving ? pend_q : '0),
                .lane_we    (we_q),
                .lane_addr  (addr_q),
                .lane_wdata (wdata_q),
                .grant      (gnt_b[b]),
                .bank_wr    (wr_b),
                .bank_wword (ww_b),
                .bank_row   (row_b)
            );

            bsm_bank #(.ROWS(ROWS), .W(W)) u_mem (
                .clk   (clk),
                .rst_n (rst_n),
                .wr    (serving && wr_b),
                .row   (row_b),
                .wword (ww_b),
                .rword (bank_rd[b])
            );
        end
    endgenerate

    always_comb begin
        gnt = '0;
        for (int b = 0; b < BANKS; b++) gnt = gnt | gnt_b[b];
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_SERVE;
            ST_SERVE: if (last_round) state_d = ST_DONE;
            ST_DONE:  state_d = req ? ST_SERVE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        ready = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_SERVE: ready = 1'b0;
            ST_DONE:  done  = 1'b1;
            default:  ready = 1'b1;
        endcase
    end

    // Request capture and per-round lane bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            we_q     <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            busy_cnt <= '0;
        end else if (accept) begin
            pend_q   <= '1;
            we_q     <= lane_we;
            addr_q   <= lane_addr;
            wdata_q  <= lane_wdata;
            busy_cnt <= '0;
        end else if (serving) begin
            pend_q   <= pend_q & ~gnt;
            busy_cnt <= busy_cnt + 1'b1;
            for (int l = 0; l < LANES; l++) begin
                if (gnt[l]) rdata_q[l*W +: W] <= bank_rd[addr_q[l*AW +: BW]];
            end
        end
    end

    assign lane_rdata = rdata_q;

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && ((pend_q & ~gnt) != '0)) |=> serving);

    a_r4_grant_ok: assert property (@(posedge clk) disable iff (!rst_n)
        serving |-> ((gnt != '0) && ((gnt & ~pend_q) == '0)));

    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        serving |-> (busy_cnt < CW'(LANES)));
endmodule

// File: tb/bsm_top_tb.sv
module bsm_top_tb;
    localparam int LANES = 8;
    localparam int BANKS = 4;
    localparam int ROWS  = 4;
    localparam int W     = 16;
    localparam int AW    = 4;
    localparam int NW    = BANKS * ROWS;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req = 1'b0;
    logic                ready;
    logic [LANES-1:0]    lane_we = '0;
    logic [LANES*AW-1:0] lane_addr = '0;
    logic [LANES*W-1:0]  lane_wdata = '0;
    logic [LANES*W-1:0]  lane_rdata;
    logic                done;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [W-1:0]  model [NW];
    logic [AW-1:0] ta  [LANES];
    logic          twe [LANES];
    logic [W-1:0]  twd [LANES];
    logic [15:0]   lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    bsm_top #(.LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
        .lane_we(lane_we), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .lane_rdata(lane_rdata), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int worst_bank();
        int best = 0;
        for (int b = 0; b < BANKS; b++) begin
            int cnt = 0;
            for (int i = 0; i < LANES; i++) begin
                bit seen = 0;
                if (int'(ta[i]) % BANKS != b) continue;
                for (int j = 0; j < i; j++) if (ta[j] == ta[i]) seen = 1;
                if (!seen) cnt++;
            end
            if (cnt > best) best = cnt;
        end
        return best;
    endfunction

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Issue the staged request; optionally poke the inputs while busy (R2).
    task automatic run_req(input bit poke, input string tag);
        logic [W-1:0] exp_rd [LANES];
        int d, n;
        bit ok;
        d = worst_bank();
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l*AW +: AW] = ta[l];
            lane_we[l]            = twe[l];
            lane_wdata[l*W +: W]  = twd[l];
            exp_rd[l]             = model[ta[l]];
        end
        for (int l = 0; l < LANES; l++) if (twe[l]) model[ta[l]] = twd[l];
        @(negedge clk);
        req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            lane_addr  = ~lane_addr;
            lane_we    = '1;
            lane_wdata = ~lane_wdata;
        end else begin
            req = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (poke && n == 1) begin
                check(ready == 1'b0, {tag, " R2 ready low while busy"}, ready, 0);
                req     = 1'b0;
                lane_we = '0;
            end
        end
        check(n == d, {tag, " R6 latency edges"}, n, d);
        ok = 1;
        for (int l = 0; l < LANES; l++) begin
            if (lane_rdata[l*W +: W] !== exp_rd[l]) begin
                if (ok) check(0, {tag, " R7 lane data"},
                              lane_rdata[l*W +: W], exp_rd[l]);
                ok = 0;
            end
        end
        if (ok) check(1, tag, 0, 0);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
        check(ready == 1'b1, {tag, " R2 ready after done"}, ready, 1);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done low in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0, "R1 ready high after reset", ready, 1);

        // R1: every word reads zero (one lane per word, two reads)
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < LANES; l++) begin
                ta[l] = AW'(p * LANES + l); twe[l] = 0; twd[l] = '0;
            end
            run_req(0, "R1 zero readback");
        end

        // R3 / R6: fill memory, lanes spread so each bank has two rows
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < LANES; l++) begin
                ta[l] = AW'(p * LANES + l); twe[l] = 1;
                twd[l] = W'(16'h1000 + p * LANES + l);
            end
            run_req(0, "R3 fill two rows per bank");
        end

        // R3 / R6: lanes sharing addresses in pairs across all banks -> D=1
        for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'(l % BANKS); twe[l] = 0; twd[l] = '0;
        end
        run_req(0, "R3 distinct banks min latency");

        // R5: broadcast of one word
        for (int l = 0; l < LANES; l++) begin
            ta[l] = 4'd9; twe[l] = 0; twd[l] = '0;
        end
        run_req(0, "R5 broadcast");

        // R4 / R6: one bank, four rows, each twice -> D=4
        for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'((l % ROWS) * BANKS); twe[l] = 0; twd[l] = '0;
        end
        run_req(0, "R4 bank conflict");

        // R6: worst case, every lane a different row of bank 1 (ROWS < LANES, so 4)
        for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'(1 + (l % ROWS) * BANKS); twe[l] = 0; twd[l] = '0;
        end
        run_req(1, "R2 poke while busy");

        // R8 / R7: all lanes write one address; highest wins, readers see old
        for (int l = 0; l < LANES; l++) begin
            ta[l] = 4'd6; twe[l] = (l % 3 != 2); twd[l] = W'(16'hB000 + l);
        end
        run_req(0, "R8 write merge");
        for (int l = 0; l < LANES; l++) begin
            ta[l] = 4'd6; twe[l] = 0; twd[l] = '0;
        end
        run_req(0, "R8 merged word readback");

        // R4 / R6 / R7 / R8: pseudo-random sweep over three address shapes
        for (int k = 0; k < 600; k++) begin
            for (int l = 0; l < LANES; l++) begin
                lfsr = step(lfsr);
                unique case (k % 3)
                    0: ta[l] = lfsr[3:0];
                    1: ta[l] = {lfsr[5:4], 2'(k % BANKS)};
                    default: ta[l] = lfsr[7] ? 4'd3 : 4'd12;
                endcase
                lfsr   = step(lfsr);
                twe[l] = lfsr[0] & lfsr[5];
                twd[l] = lfsr ^ W'(k);
            end
            run_req(0, "R4 random sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule